// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block models a single-port synchronous static RAM that has a shared data path and a burst address sequencer. It can sit behind a processor or a cache controller. Every control input is sampled on the rising clock edge. An access opens when one of two address strobes is low. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write inputs in that same cycle. Later beats of a burst need no strobe. An advance input steps the two low address bits in linear or interleaved order. When the advance input is inactive, the beat address holds.

Each word has four 9-bit byte lanes. Each lane is eight data bits plus one parity bit. A write either fills the whole word or only selected lanes. Read data comes combinationally from the registered beat address, so it appears in the cycle after the edge that set up the access. The bus is split into `dq_i`, `dq_o` and a drive enable `dq_oe`. The enable is low whenever the pads of a shared bus would float.

An output-enable input and a sleep input force the bus to float without waiting for a clock edge. Sleep also blocks writes and closes any open access.

Top module: `sram_ft_top`

## Requirements
- R1: An access is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on the strobe edge. A strobe that finds the chip deselected closes the access: the array is not written, and `dq_oe` is low from the next cycle on.
- R2: On a strobe edge, `addr_i` is captured. In a later cycle with no strobe, `adv_n`=0 steps the beat and `adv_n`=1 repeats the current beat address.
- R3: On the edge where `adsp_n`=0 and `ce1_n`=0, the write inputs are ignored. That cycle is a read, and the word read is unchanged.
- R4: On an edge where `adsc_n`=0 and the processor strobe does not take effect, the access opens. A write requested on that same edge stores `dq_i` at `addr_i`.
- R5: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R6: With `gw_n`=1 and `bwe_n`=0, lane i (bits 9i+8 down to 9i of the word) is written exactly when `bw_n[i]`=0.
- R7: With `gw_n`=1 and `bwe_n`=1, the cycle is a read and the array is unchanged.
- R8: `oe_n`=1 forces `dq_oe` low in the same cycle, without waiting for a clock edge.
- R9: After a write cycle, `dq_oe` stays low through plain burst cycles until a strobe opens a new read.
- R10: In the cycle after a read edge, `dq_o` equals the array word at the beat address registered on that edge. No extra register stage is added.
- R11: While `sleep`=1, `dq_oe` is low and no write takes place. The access closes, and `dq_oe` stays low after sleep ends until a strobe opens a read.
- R12: A processor strobe with `ce1_n`=1 is ignored. The cycle then follows the controller strobe if it is low; otherwise it is a plain burst cycle.
- R13: Beat n of a burst that starts at low bits s uses low bits (s+n) mod 4 when `burst_ilv`=0, and s XOR n when `burst_ilv`=1. The burst wraps after four beats, and the upper address bits stay fixed.
- R14: A synchronous reset (`rst_n`=0) closes any access, drives `dq_oe` low and clears every array word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Word address, captured on a strobe edge |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data from the registered beat address |
| dq_oe | output | 1 | High when the block drives the bus |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Sleep request, active high, acts without a clock edge |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |

## Verification
A write takes effect on the edge that samples it. Its data can be read back from the cycle after the next strobe or burst step that selects the same word. A read, the drive enable after a strobe, and a burst step all show their results in the cycle that follows the sampling edge, with no further delay. The bench drives inputs just after the falling edge and updates its reference model at the rising edge. It compares `dq_oe`, and `dq_o` whenever the bus is driven, at the next falling edge, which is exactly where those one-edge results are due. The output-enable and sleep inputs need no clock, so they are also checked one time step after they change, in the middle of a cycle.

// File: rtl/sram_ft_pkg.sv
// Package: shared types and the burst-order function of the flow-through SRAM.
// Assumes the burst spans the two low address bits (four beats).
package sram_ft_pkg;

    localparam int BEAT_BITS = 2;

    typedef logic [BEAT_BITS-1:0] beat_t;

    typedef enum logic [1:0] {
        OPEN_NONE = 2'd0,
        OPEN_PROC = 2'd1,
        OPEN_CTRL = 2'd2
    } open_e;

    // Low address bits of beat n for a burst that starts at s.
    function automatic beat_t beat_lo(input beat_t s, input beat_t n, input logic ilv);
        beat_t r;
        if (ilv) r = s ^ n;
        else     r = s + n;
        return r;
    endfunction

endpackage

// File: rtl/sram_ft_wdec.sv
// Write decoder: turns global write, byte-write enable and lane enables
// into a per-lane write mask. Global write wins over everything else.
// Purely combinational; assumes all inputs are active low.
module sram_ft_wdec #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);

    // Lane mask selection by write priority.
    always_comb begin
        if (!gw_n)       lane_we = '1;
        else if (!bwe_n) lane_we = ~bw_n;
        else             lane_we = '0;
    end

    // Any lane selected means the cycle is a write.
    assign wr_req = |lane_we;

endmodule

// File: rtl/sram_ft_burst.sv
// Burst sequencer: holds the start offset and beat count of the open burst.
// Gives the beat low bits for the current edge combinationally (nxt_lo)
// and the registered beat low bits (cur_lo) that feed the read path.
// Assumes burst_ilv is static while a burst is open.
module sram_ft_burst
    import sram_ft_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  step,
    input  beat_t start_lo,
    input  logic  burst_ilv,
    output beat_t nxt_lo,
    output beat_t cur_lo
);

    beat_t start_q;
    beat_t cnt_q;
    beat_t cnt_nxt;
    beat_t start_nxt;

    // Next start offset and beat count.
    always_comb begin
        start_nxt = start_q;
        cnt_nxt   = cnt_q;
        if (load) begin
            start_nxt = start_lo;
            cnt_nxt   = '0;
        end else if (step) begin
            cnt_nxt = cnt_q + beat_t'(1);
        end
    end

    // Beat address used by the access on this edge.
    assign nxt_lo = beat_lo(start_nxt, cnt_nxt, burst_ilv);

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            cur_lo  <= '0;
        end else begin
            start_q <= start_nxt;
            cnt_q   <= cnt_nxt;
            cur_lo  <= nxt_lo;
        end
    end

endmodule

// File: rtl/sram_ft_ctl.sv
// Access controller: decides on each edge whether a strobe opens an access,
// a burst continues, or the block is deselected, and whether that edge
// writes. Tracks the output drive flag, which a strobe-opened read sets and
// a write, deselect, sleep or reset clears.
module sram_ft_ctl
    import sram_ft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic adv_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic sleep,
    input  logic wr_req,
    output logic load,
    output logic step,
    output logic wr_go,
    output logic drive_q
);

    logic  active_q;
    logic  active_nxt;
    logic  drive_nxt;
    logic  sel;
    open_e opener;

    assign sel = !ce1_n && ce2 && !ce3_n;

    // Strobe arbitration: the processor strobe needs ce1_n low and wins.
    always_comb begin
        if (!adsp_n && !ce1_n) opener = OPEN_PROC;
        else if (!adsc_n)      opener = OPEN_CTRL;
        else                   opener = OPEN_NONE;
    end

    // Next-state and command decode for this edge.
    always_comb begin
        load       = 1'b0;
        step       = 1'b0;
        wr_go      = 1'b0;
        active_nxt = active_q;
        drive_nxt  = drive_q;
        if (sleep) begin
            active_nxt = 1'b0;
            drive_nxt  = 1'b0;
        end else begin
            case (opener)
                OPEN_PROC: begin
                    load       = sel;
                    active_nxt = sel;
                    drive_nxt  = sel;
                end
                OPEN_CTRL: begin
                    load       = sel;
                    active_nxt = sel;
                    wr_go      = sel && wr_req;
                    drive_nxt  = sel && !wr_req;
                end
                default: begin
                    if (active_q) begin
                        step  = !adv_n;
                        wr_go = wr_req;
                        if (wr_req) drive_nxt = 1'b0;
                    end
                end
            endcase
        end
    end

    // Access and drive state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            drive_q  <= 1'b0;
        end else begin
            active_q <= active_nxt;
            drive_q  <= drive_nxt;
        end
    end

endmodule

// File: rtl/sram_ft_lane.sv
// One byte lane of the array: synchronous write, combinational read.
// Cleared to zero by the synchronous reset.
module sram_ft_lane #(
    parameter int AW     = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [LANE_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Flow-through read.
    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_ft_top.sv
// Flow-through burst SRAM top: address register, burst sequencer, access
// controller, write decoder and one array slice per byte lane.
// Assumes AW > 2 so that the burst bits sit below the upper address.
module sram_ft_top #(
    parameter  int AW     = 6,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DW     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    dq_i,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic             burst_ilv
);
    import sram_ft_pkg::*;

    localparam int HI_W = AW - BEAT_BITS;

    logic [LANES-1:0] lane_we;
    logic             wr_req;
    logic             load;
    logic             step;
    logic             wr_go;
    logic             drive_q;
    beat_t            nxt_lo;
    beat_t            cur_lo;
    logic [HI_W-1:0]  hi_q;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;

    sram_ft_wdec #(.LANES(LANES)) u_wdec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we),
        .wr_req  (wr_req)
    );

    sram_ft_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .sleep   (sleep),
        .wr_req  (wr_req),
        .load    (load),
        .step    (step),
        .wr_go   (wr_go),
        .drive_q (drive_q)
    );

    sram_ft_burst u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .start_lo  (addr_i[BEAT_BITS-1:0]),
        .burst_ilv (burst_ilv),
        .nxt_lo    (nxt_lo),
        .cur_lo    (cur_lo)
    );

    // Upper address register, loaded on an opening strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_q <= '0;
        else if (load) hi_q <= addr_i[AW-1:BEAT_BITS];
    end

    assign waddr = load ? addr_i : {hi_q, nxt_lo};
    assign raddr = {hi_q, cur_lo};

    // One array slice per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ft_lane #(.AW(AW), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go && lane_we[g]),
            .waddr (waddr),
            .wdata (dq_i[g*LANE_W +: LANE_W]),
            .raddr (raddr),
            .rdata (dq_o[g*LANE_W +: LANE_W])
        );
    end

    // Bus drive: the registered flag, gated without a clock by oe_n and sleep.
    assign dq_oe = drive_q && !oe_n && !sleep;

endmodule

// File: rtl/sram_ft_chk.sv
// Checker for the flow-through SRAM: port-level properties on bus drive.
module sram_ft_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adsp_n,
    input logic             adsc_n,
    input logic             ce1_n,
    input logic             ce2,
    input logic             ce3_n,
    input logic             gw_n,
    input logic             bwe_n,
    input logic [LANES-1:0] bw_n,
    input logic             oe_n,
    input logic             sleep,
    input logic             dq_oe
);

    logic sel_c;
    logic pstart_c;
    logic opens_c;
    logic wrq_c;

    assign sel_c    = !ce1_n && ce2 && !ce3_n;
    assign pstart_c = !adsp_n && !ce1_n;
    assign opens_c  = pstart_c || !adsc_n;
    assign wrq_c    = !gw_n || (!bwe_n && !(&bw_n));

    AST_OE_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R8

    AST_SLEEP_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe); // R11

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (opens_c && !sel_c) |=> !dq_oe); // R1

    AST_PROC_OPEN_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart_c && sel_c && !sleep) |=> (dq_oe || oe_n || sleep)); // R3

    AST_CTRL_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && sel_c && wrq_c && !sleep) |=> !dq_oe); // R9

endmodule

bind sram_ft_top sram_ft_chk #(.LANES(LANES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .oe_n   (oe_n),
    .sleep  (sleep),
    .dq_oe  (dq_oe)
);

// File: tb/sram_ft_top_bench.sv
// Bench: behavioural reference model updated at each rising edge,
// outputs compared at each falling edge.
module sram_ft_top_bench;

    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int LANE_W = 9;
    localparam int DW = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic dq_oe;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic gw_n = 1'b1, bwe_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic oe_n = 1'b0, sleep = 1'b0, burst_ilv = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    bit m_act = 0, m_drv = 0;
    int m_hi = 0, m_st = 0, m_cnt = 0;

    always #5 clk = ~clk;

    sram_ft_top #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_sram_ft_top (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .burst_ilv(burst_ilv)
    );

    function automatic int m_addr();
        int lo;
        if (burst_ilv) lo = m_st ^ m_cnt;
        else           lo = (m_st + m_cnt) % 4;
        return m_hi * 4 + lo;
    endfunction

    function automatic logic [LANES-1:0] m_mask();
        if (!gw_n) return '1;
        if (!bwe_n) return ~bw_n;
        return '0;
    endfunction

    task automatic m_write(input int a, input logic [LANES-1:0] mk);
        for (int l = 0; l < LANES; l++)
            if (mk[l]) m_mem[a][l*LANE_W +: LANE_W] = dq_i[l*LANE_W +: LANE_W];
    endtask

    // Model update for one rising edge, from the sampled inputs.
    task automatic m_edge();
        bit sel, pgo;
        logic [LANES-1:0] mk;
        sel = !ce1_n && ce2 && !ce3_n;
        pgo = !adsp_n && !ce1_n;
        mk = m_mask();
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            m_act = 0; m_drv = 0; m_hi = 0; m_st = 0; m_cnt = 0;
        end else if (sleep) begin
            m_act = 0; m_drv = 0;
        end else if (pgo || !adsc_n) begin
            if (sel) begin
                m_hi = int'(addr_i) / 4; m_st = int'(addr_i) % 4; m_cnt = 0; m_act = 1;
                if (!pgo && mk != 0) begin
                    m_write(m_addr(), mk); m_drv = 0;
                end else m_drv = 1;
            end else begin
                m_act = 0; m_drv = 0;
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            if (mk != 0) begin
                m_write(m_addr(), mk); m_drv = 0;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit eoe;
        eoe = m_drv && !oe_n && !sleep;
        n_cmp++;
        if (dq_oe !== eoe) begin
            n_bad++;
            $display("FAIL %s dq_oe actual %0b expected %0b at %0t", tag, dq_oe, eoe, $time);
        end else if (eoe && dq_o !== m_mem[m_addr()]) begin
            n_bad++;
            $display("FAIL %s dq_o actual %h expected %h at %0t", tag, dq_o, m_mem[m_addr()], $time);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        m_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; sleep = 0;
    endtask

    task automatic ctrl_wr(input int a, input logic [DW-1:0] d, input string tag);
        idle(); adsc_n = 0; addr_i = AW'(a); dq_i = d; gw_n = 0; cyc(tag);
    endtask

    task automatic ctrl_rd(input int a, input string tag);
        idle(); adsc_n = 0; addr_i = AW'(a); cyc(tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 0; idle();
        repeat (3) cyc("R14 reset");
        rst_n = 1;
        cyc("R14 after reset");
        ctrl_rd(3, "R14 cleared word");

        // Controller-strobe full write, then processor read with writes asserted
        ctrl_wr(5, 36'hA_5A5A_5A5A, "R4 R5 ctrl write");
        idle(); adsp_n = 0; addr_i = 5; gw_n = 0; dq_i = '1; cyc("R3 proc ignores writes");
        cyc("R10 flow-through read");

        // Byte write lanes 0 and 2
        idle(); adsc_n = 0; addr_i = 5; bwe_n = 0; bw_n = 4'b1010; dq_i = 36'h1_2345_6789;
        cyc("R6 byte write");
        ctrl_rd(5, "R6 lane readback");
        idle(); adsc_n = 0; addr_i = 5; dq_i = '0; bw_n = 4'b0000; cyc("R7 no write");
        cyc("R7 contents unchanged");

        // Fill a burst block, then linear read from offset 2
        for (int i = 8; i < 12; i++) ctrl_wr(i, DW'(36'h1_1111_0000 + i * 7), "R4 fill");
        idle(); burst_ilv = 0; adsp_n = 0; addr_i = 10; cyc("R13 linear start");
        for (int k = 0; k < 4; k++) begin
            idle(); adv_n = 0; cyc("R13 linear beat");
        end
        idle(); cyc("R2 suspend holds");
        cyc("R2 suspend holds again");
        idle(); burst_ilv = 1; adsc_n = 0; addr_i = 9; cyc("R13 interleaved start");
        for (int k = 0; k < 4; k++) begin
            idle(); burst_ilv = 1; adv_n = 0; cyc("R13 interleaved beat");
        end
        burst_ilv = 0;

        // Write in a processor-opened burst, then bus floats until a new strobe
        idle(); adsp_n = 0; addr_i = 8; cyc("R3 proc open");
        idle(); adv_n = 0; gw_n = 0; dq_i = 36'h3_CAFE_0001; cyc("R9 burst write");
        idle(); adv_n = 0; cyc("R9 floats after write");
        ctrl_rd(9, "R9 new strobe read drives");

        // Deselected strobe: no write, bus floats
        idle(); adsc_n = 0; ce2 = 0; addr_i = 9; gw_n = 0; dq_i = '0; cyc("R1 deselect");
        idle(); ce3_n = 1; adsp_n = 0; addr_i = 9; cyc("R1 deselect ce3");
        ctrl_rd(9, "R1 word kept");

        // Processor strobe with ce1_n high is ignored; burst continues with write
        ctrl_rd(20, "R12 open");
        idle(); ce1_n = 1; adsp_n = 0; addr_i = 40; gw_n = 0; dq_i = 36'h7_7777_7777;
        cyc("R12 proc ignored");
        ctrl_rd(20, "R12 write landed at burst word");
        ctrl_rd(40, "R12 no load of proc address");

        // Output enable without clock
        ctrl_rd(5, "R8 drive");
        #2 oe_n = 1; #1;
        n_cmp++;
        if (dq_oe !== 1'b0) begin
            n_bad++; $display("FAIL R8 dq_oe actual %0b expected 0", dq_oe);
        end
        oe_n = 0; #1;
        n_cmp++;
        if (dq_oe !== 1'b1) begin
            n_bad++; $display("FAIL R8 dq_oe actual %0b expected 1", dq_oe);
        end

        // Sleep: floats, blocks writes, stays floating after exit
        idle(); adsc_n = 0; ce2 = 0; cyc("R11 deselect before sleep");
        idle(); sleep = 1; adsc_n = 0; addr_i = 5; gw_n = 0; dq_i = '0; cyc("R11 sleep write blocked");
        idle(); sleep = 1; cyc("R11 sleep");
        idle(); cyc("R11 floats after exit");
        ctrl_rd(5, "R11 word kept");

        // Random mix against the model
        for (int i = 0; i < 600; i++) begin
            idle();
            adsp_n = ($urandom_range(0, 3) != 0);
            adsc_n = ($urandom_range(0, 3) != 0);
            adv_n = $urandom_range(0, 1);
            ce1_n = ($urandom_range(0, 7) == 0);
            ce2 = ($urandom_range(0, 7) != 0);
            ce3_n = ($urandom_range(0, 7) == 0);
            gw_n = ($urandom_range(0, 4) != 0);
            bwe_n = $urandom_range(0, 1);
            bw_n = LANES'($urandom);
            oe_n = ($urandom_range(0, 7) == 0);
            sleep = ($urandom_range(0, 31) == 0);
            burst_ilv = $urandom_range(0, 1);
            addr_i = AW'($urandom);
            dq_i = {4'($urandom), 32'($urandom)};
            cyc("R2 R13 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule